// File: doc/BRIEF.md
# SDRAM Bank Command Legality Monitor

This block watches the command pins of an SDRAM device on every rising clock edge and checks each command against a model of the four banks. It decodes the chip-select, row-strobe, column-strobe and write-enable levels into a command. It keeps a state machine and a set of down-counters for every bank, and it raises a one-cycle error with a reason code when a command breaks the bank protocol or a minimum delay. It is meant to sit beside a memory controller in simulation or in silicon as a protocol watchdog. It stores no data.

Each bank moves through these states: idle, opening (row activation in progress), open, reading, writing, reading or writing with automatic close, write recovery, closing (precharge), refreshing and mode-register busy. A command that is rejected changes no bank state. Running delays continue to count down during the cycle in which the command is rejected. The row-open, precharge, row-hold and activate-spacing delays are parameters in clocks; the defaults match a 100 MHz speed grade.

Top module: `sdram_cmd_checker`

## Requirements
- R1: When cke is high and cs_n is low, the command code is {ras_n,cas_n,we_n} with 0 mode set, 1 refresh, 2 precharge, 3 activate, 4 write, 5 read, 6 burst stop and 7 no-op. cs_n high gives code 8 (deselect). cke low gives code 7, and that command has no effect. cmd_o shows the code of the command sampled at the last edge.
- R2: ba selects bank 0 to 3. Each bank's state is bank_state_o[4*b+3:4*b]: 0 idle, 1 opening, 2 open, 3 read, 4 write, 5 read with auto-close, 6 write with auto-close, 7 write recovery, 8 closing, 9 refreshing, 10 mode busy.
- R3: An activate to an idle bank makes the bank opening. It becomes open so that a read or write issued TRCD (3) clocks after the activate is legal. One issued earlier is rejected with code 4 (bank busy).
- R4: A read or write to an idle bank is rejected with code 1. An activate to a bank that is open, reading, writing or in write recovery is rejected with code 2.
- R5: A precharge with a10 low closes only the bank named by ba. With a10 high it closes every open bank and leaves idle banks idle. A closing bank is idle TRP (3) clocks after the precharge.
- R6: A precharge issued fewer than TRAS (5) clocks after the activate of a bank that it would close is rejected with code 5.
- R7: An activate fewer than TRRD (2) clocks after the previous accepted activate, to any bank, is rejected with code 6.
- R8: Mode set and refresh need every bank idle, otherwise they are rejected with code 3. Mode set makes all banks mode busy for TMRD (2) clocks. Refresh makes all banks refreshing for TRFC (8) clocks. Any command to a bank in these states is rejected with code 4.
- R9: A read with a10 low keeps the bank in read for BURST_LEN (4) clocks, then the bank is open again. A read or write with a10 high enters the auto-close state. During that state any command to the bank is rejected with code 4. The bank then closes by itself and becomes idle.
- R10: A write keeps the bank in write for BURST_LEN-1 clocks after the command, then in write recovery for TWR (1) clock, then the bank is open. A burst stop returns every bank in read or write to open at once.
- R11: A rejected command changes no bank state. A command is checked only against the state of the bank or banks it targets. When several banks reject one command, the code of the lowest-numbered bank is reported.
- R12: err_o, err_code_o, cmd_o and bank_state_o all update at the clock edge that samples the command. err_o lasts one cycle per rejected command. Reset clears all banks to idle, err_o to 0 and cmd_o to 7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the command bus is sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cke | input | 1 | Clock enable of the monitored device |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 2 | Bank address |
| a10 | input | 1 | Auto-close for read and write; all-bank select for precharge |
| cmd_o | output | 4 | Decoded command of the last edge |
| bank_state_o | output | 16 | State code of every bank, 4 bits per bank |
| err_o | output | 1 | One-cycle pulse for a rejected command |
| err_code_o | output | 3 | Reason for the rejection, 0 when none |

## Verification
A bank left in the wrong state shows up directly on bank_state_o at the edge of the command that caused it. A delay counter that is off by one shows up as a legal command rejected, or an illegal one accepted, exactly at the boundary clock TRCD, TRP, TRAS or TRRD after its command. The directed scenarios therefore issue commands one clock before and at each boundary. They read the state field of every touched bank after each edge. A wrong priority or a broken targeting path gives a wrong err_code_o, or a state change in a bank that the command did not address.

// File: rtl/sdram_chk_pkg.sv
package sdram_chk_pkg;

    typedef enum logic [3:0] {
        CMD_MRS   = 4'd0,
        CMD_REF   = 4'd1,
        CMD_PRE   = 4'd2,
        CMD_ACT   = 4'd3,
        CMD_WR    = 4'd4,
        CMD_RD    = 4'd5,
        CMD_BST   = 4'd6,
        CMD_NOP   = 4'd7,
        CMD_DESEL = 4'd8
    } cmd_e;

    typedef enum logic [3:0] {
        BS_IDLE      = 4'd0,
        BS_OPENING   = 4'd1,
        BS_ACTIVE    = 4'd2,
        BS_READ      = 4'd3,
        BS_WRITE     = 4'd4,
        BS_READ_AP   = 4'd5,
        BS_WRITE_AP  = 4'd6,
        BS_WR_RECOV  = 4'd7,
        BS_PRECHG    = 4'd8,
        BS_REFRESH   = 4'd9,
        BS_MODE_BUSY = 4'd10
    } bank_st_e;

    typedef enum logic [2:0] {
        VIO_NONE        = 3'd0,
        VIO_IDLE_ACCESS = 3'd1,
        VIO_ROW_OPEN    = 3'd2,
        VIO_NOT_IDLE    = 3'd3,
        VIO_BUSY        = 3'd4,
        VIO_RAS         = 3'd5,
        VIO_RRD         = 3'd6
    } vio_e;

    typedef struct packed {
        cmd_e op;
        logic ap;
    } bus_cmd_t;

    localparam int unsigned ST_W = 4;

    function automatic cmd_e decode_cmd(input logic cke, input logic cs_n,
                                        input logic ras_n, input logic cas_n,
                                        input logic we_n);
        if (!cke)
            return CMD_NOP;
        if (cs_n)
            return CMD_DESEL;
        return cmd_e'({1'b0, ras_n, cas_n, we_n});
    endfunction

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    function automatic logic is_open(input bank_st_e s);
        return (s == BS_ACTIVE) || (s == BS_READ) || (s == BS_WRITE) || (s == BS_WR_RECOV);
    endfunction

    function automatic logic is_transient(input bank_st_e s);
        return (s == BS_OPENING) || (s == BS_READ_AP) || (s == BS_WRITE_AP) ||
               (s == BS_REFRESH) || (s == BS_MODE_BUSY);
    endfunction

endpackage

// File: rtl/sdram_act_spacing.sv
module sdram_act_spacing #(
    parameter int unsigned TRRD = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic act_fire,
    output logic busy_o
);
    localparam int unsigned W = $clog2(TRRD + 1);

    logic [W-1:0] gap_q;

    always_ff @(posedge clk) begin
        if (rst)
            gap_q <= '0;
        else if (act_fire)
            gap_q <= W'(TRRD - 1);
        else if (gap_q != '0)
            gap_q <= gap_q - 1'b1;
    end

    assign busy_o = (gap_q != '0);
endmodule

// File: rtl/sdram_bank_tracker.sv
module sdram_bank_tracker
    import sdram_chk_pkg::*;
#(
    parameter int unsigned TRCD      = 3,
    parameter int unsigned TRP       = 3,
    parameter int unsigned TRAS      = 5,
    parameter int unsigned TRFC      = 8,
    parameter int unsigned TMRD      = 2,
    parameter int unsigned BURST_LEN = 4,
    parameter int unsigned TWR       = 1
) (
    input  logic     clk,
    input  logic     rst,
    input  bus_cmd_t cmd,
    input  logic     hit,
    input  logic     commit,
    input  logic     rrd_busy,
    output bank_st_e state_o,
    output vio_e     vio_o
);
    localparam int unsigned CNT_MAX = max2(max2(max2(TRCD, TRP), max2(TRFC, TMRD)),
                                           BURST_LEN + TWR);
    localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1);
    localparam int unsigned RAS_W   = $clog2(TRAS + 1);

    typedef logic [CNT_W-1:0] cnt_t;

    function automatic cnt_t ld(input int unsigned n);
        return cnt_t'(n - 1);
    endfunction

    bank_st_e         st_q, st_d;
    cnt_t             cnt_q, cnt_d;
    logic [RAS_W-1:0] ras_q, ras_d;
    logic             expired;

    assign expired = (cnt_q <= cnt_t'(1));

    // Legality of the current command against this bank only
    always_comb begin
        vio_o = VIO_NONE;
        if (hit) begin
            case (cmd.op)
                CMD_MRS, CMD_REF:
                    if (st_q != BS_IDLE) vio_o = VIO_NOT_IDLE;
                CMD_ACT:
                    if (st_q == BS_IDLE)
                        vio_o = rrd_busy ? VIO_RRD : VIO_NONE;
                    else if (is_open(st_q))
                        vio_o = VIO_ROW_OPEN;
                    else
                        vio_o = VIO_BUSY;
                CMD_RD, CMD_WR:
                    if (st_q == BS_IDLE)
                        vio_o = VIO_IDLE_ACCESS;
                    else if (!is_open(st_q))
                        vio_o = VIO_BUSY;
                CMD_PRE:
                    if (is_transient(st_q) || st_q == BS_WR_RECOV)
                        vio_o = VIO_BUSY;
                    else if (is_open(st_q) && ras_q != '0)
                        vio_o = VIO_RAS;
                default: vio_o = VIO_NONE;
            endcase
        end
    end

    // Timed progression, then the accepted command on top
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        ras_d = (ras_q != '0) ? ras_q - 1'b1 : ras_q;
        if (!expired) begin
            cnt_d = cnt_q - 1'b1;
        end else begin
            case (st_q)
                BS_OPENING, BS_READ, BS_WR_RECOV: st_d = BS_ACTIVE;
                BS_PRECHG, BS_REFRESH, BS_MODE_BUSY: st_d = BS_IDLE;
                BS_WRITE: begin
                    st_d  = BS_WR_RECOV;
                    cnt_d = ld(TWR);
                end
                BS_READ_AP, BS_WRITE_AP: begin
                    st_d  = BS_PRECHG;
                    cnt_d = ld(TRP);
                end
                default: ;
            endcase
        end
        if (hit && commit) begin
            case (cmd.op)
                CMD_ACT: begin
                    st_d  = BS_OPENING;
                    cnt_d = ld(TRCD);
                    ras_d = RAS_W'(TRAS - 1);
                end
                CMD_RD: begin
                    st_d  = cmd.ap ? BS_READ_AP : BS_READ;
                    cnt_d = ld(BURST_LEN);
                end
                CMD_WR: begin
                    st_d  = cmd.ap ? BS_WRITE_AP : BS_WRITE;
                    cnt_d = cmd.ap ? ld(BURST_LEN + TWR) : ld(BURST_LEN);
                end
                CMD_PRE:
                    if (st_q == BS_ACTIVE || st_q == BS_READ || st_q == BS_WRITE) begin
                        st_d  = BS_PRECHG;
                        cnt_d = ld(TRP);
                    end
                CMD_BST:
                    if (st_q == BS_READ || st_q == BS_WRITE) st_d = BS_ACTIVE;
                CMD_REF: begin
                    st_d  = BS_REFRESH;
                    cnt_d = ld(TRFC);
                end
                CMD_MRS: begin
                    st_d  = BS_MODE_BUSY;
                    cnt_d = ld(TMRD);
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= BS_IDLE;
            cnt_q <= '0;
            ras_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
            ras_q <= ras_d;
        end
    end

    assign state_o = st_q;
endmodule

// File: rtl/sdram_cmd_checker.sv
module sdram_cmd_checker
    import sdram_chk_pkg::*;
#(
    parameter int unsigned NUM_BANKS = 4,
    parameter int unsigned TRCD      = 3,
    parameter int unsigned TRP       = 3,
    parameter int unsigned TRAS      = 5,
    parameter int unsigned TRRD      = 2,
    parameter int unsigned TRFC      = 8,
    parameter int unsigned TMRD      = 2,
    parameter int unsigned BURST_LEN = 4,
    parameter int unsigned TWR       = 1,
    localparam int unsigned BA_W     = $clog2(NUM_BANKS)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      cke,
    input  logic                      cs_n,
    input  logic                      ras_n,
    input  logic                      cas_n,
    input  logic                      we_n,
    input  logic [BA_W-1:0]           ba,
    input  logic                      a10,
    output logic [3:0]                cmd_o,
    output logic [NUM_BANKS*ST_W-1:0] bank_state_o,
    output logic                      err_o,
    output logic [2:0]                err_code_o
);
    bus_cmd_t              cur;
    logic                  broadcast, targeted, commit, rrd_busy, act_fire;
    logic [NUM_BANKS-1:0]  hit;
    vio_e                  vio [NUM_BANKS];
    vio_e                  sel;
    cmd_e                  cmd_q;
    vio_e                  code_q;

    assign cur.op  = decode_cmd(cke, cs_n, ras_n, cas_n, we_n);
    assign cur.ap  = a10;
    assign broadcast = (cur.op == CMD_MRS) || (cur.op == CMD_REF) || (cur.op == CMD_BST) ||
                       (cur.op == CMD_PRE && a10);
    assign targeted  = (cur.op == CMD_ACT) || (cur.op == CMD_RD) || (cur.op == CMD_WR) ||
                       (cur.op == CMD_PRE && !a10);

    sdram_act_spacing #(.TRRD(TRRD)) u_spacing (
        .clk     (clk),
        .rst     (rst),
        .act_fire(act_fire),
        .busy_o  (rrd_busy)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        bank_st_e st;
        assign hit[b] = broadcast || (targeted && ba == BA_W'(b));
        sdram_bank_tracker #(
            .TRCD(TRCD), .TRP(TRP), .TRAS(TRAS), .TRFC(TRFC),
            .TMRD(TMRD), .BURST_LEN(BURST_LEN), .TWR(TWR)
        ) u_bank (
            .clk     (clk),
            .rst     (rst),
            .cmd     (cur),
            .hit     (hit[b]),
            .commit  (commit),
            .rrd_busy(rrd_busy),
            .state_o (st),
            .vio_o   (vio[b])
        );
        assign bank_state_o[b*ST_W +: ST_W] = st;
    end

    // Lowest-numbered complaining bank wins
    always_comb begin
        sel = VIO_NONE;
        for (int i = NUM_BANKS - 1; i >= 0; i--)
            if (vio[i] != VIO_NONE) sel = vio[i];
    end

    assign commit   = (sel == VIO_NONE);
    assign act_fire = commit && (cur.op == CMD_ACT);

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q  <= CMD_NOP;
            code_q <= VIO_NONE;
            err_o  <= 1'b0;
        end else begin
            cmd_q  <= cur.op;
            code_q <= sel;
            err_o  <= !commit;
        end
    end

    assign cmd_o      = cmd_q;
    assign err_code_o = code_q;
endmodule

// File: rtl/sdram_cmd_checker_sva.sv
module sdram_cmd_checker_sva
    import sdram_chk_pkg::*;
#(
    parameter int unsigned NUM_BANKS = 4,
    parameter int unsigned TRRD      = 2,
    localparam int unsigned BA_W     = $clog2(NUM_BANKS)
) (
    input logic                      clk,
    input logic                      rst,
    input logic                      cke,
    input logic [BA_W-1:0]           ba,
    input logic [3:0]                cmd_o,
    input logic [NUM_BANKS*ST_W-1:0] bank_state_o,
    input logic                      err_o,
    input logic [2:0]                err_code_o
);
    // R3
    act_opens_bank_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_o == 4'(CMD_ACT) && !err_o) |->
            bank_state_o[ST_W*$past(ba) +: ST_W] == 4'(BS_OPENING));

    // R4
    idle_access_cmd_chk: assert property (@(posedge clk) disable iff (rst)
        (err_o && err_code_o == 3'(VIO_IDLE_ACCESS)) |->
            (cmd_o == 4'(CMD_RD) || cmd_o == 4'(CMD_WR)));

    // R1
    cke_low_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        $past(!cke) |-> (cmd_o == 4'(CMD_NOP) && !err_o));

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank_chk
        // R8
        mode_set_all_busy_chk: assert property (@(posedge clk) disable iff (rst)
            (cmd_o == 4'(CMD_MRS) && !err_o) |->
                bank_state_o[b*ST_W +: ST_W] == 4'(BS_MODE_BUSY));
        // R2
        state_code_range_chk: assert property (@(posedge clk) disable iff (rst)
            bank_state_o[b*ST_W +: ST_W] <= 4'(BS_MODE_BUSY));
    end

    if (TRRD >= 2) begin : g_rrd_chk
        // R7
        act_spacing_chk: assert property (@(posedge clk) disable iff (rst)
            (cmd_o == 4'(CMD_ACT) && !err_o) |=> !(cmd_o == 4'(CMD_ACT) && !err_o));
    end
endmodule

bind sdram_cmd_checker sdram_cmd_checker_sva #(
    .NUM_BANKS(NUM_BANKS),
    .TRRD     (TRRD)
) u_sva (
    .clk         (clk),
    .rst         (rst),
    .cke         (cke),
    .ba          (ba),
    .cmd_o       (cmd_o),
    .bank_state_o(bank_state_o),
    .err_o       (err_o),
    .err_code_o  (err_code_o)
);

// File: tb/test_sdram_cmd_checker.sv
module test_sdram_cmd_checker;
    localparam int C_MRS = 0, C_REF = 1, C_PRE = 2, C_ACT = 3, C_WR = 4, C_RD = 5,
                   C_BST = 6, C_NOP = 7, C_DESEL = 8;

    logic        clk = 1'b0;
    logic        rst, cke, cs_n, ras_n, cas_n, we_n, a10;
    logic [1:0]  ba;
    logic [3:0]  cmd_o;
    logic [15:0] bank_state_o;
    logic        err_o;
    logic [2:0]  err_code_o;
    int          checks = 0;
    int          fails  = 0;

    always #5 clk = ~clk;

    sdram_cmd_checker i_sdram_cmd_checker (
        .clk(clk), .rst(rst), .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
        .we_n(we_n), .ba(ba), .a10(a10), .cmd_o(cmd_o), .bank_state_o(bank_state_o),
        .err_o(err_o), .err_code_o(err_code_o)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int st(input int b);
        return int'(bank_state_o[b*4 +: 4]);
    endfunction

    task automatic issue_ck(input int code, input int b, input logic a, input logic ck);
        @(negedge clk);
        cke = ck;
        if (code == C_DESEL) {cs_n, ras_n, cas_n, we_n} = 4'b1111;
        else                 {cs_n, ras_n, cas_n, we_n} = 4'(code);
        ba  = 2'(b);
        a10 = a;
        @(posedge clk);
        #2;
    endtask

    task automatic issue(input int code, input int b, input logic a);
        issue_ck(code, b, a, 1'b1);
    endtask

    task automatic nops(input int n);
        for (int i = 0; i < n; i++) issue(C_NOP, 0, 1'b0);
    endtask

    task automatic expect_ok(input string req, input int code);
        check({req, " cmd"}, int'(cmd_o), code);
        check({req, " no error"}, int'(err_o), 0);
    endtask

    task automatic expect_err(input string req, input int code);
        check({req, " err"}, int'(err_o), 1);
        check({req, " code"}, int'(err_code_o), code);
    endtask

    task automatic close_all();
        nops(6);
        issue(C_PRE, 0, 1'b1);
        nops(2);
    endtask

    task automatic t_reset();
        rst = 1'b1; cke = 1'b1; ba = '0; a10 = 1'b0;
        {cs_n, ras_n, cas_n, we_n} = 4'b0111;
        repeat (3) @(posedge clk);
        @(negedge clk);
        for (int b = 0; b < 4; b++) check("R12 reset bank idle", st(b), 0);
        check("R12 reset err", int'(err_o), 0);
        check("R12 reset cmd", int'(cmd_o), C_NOP);
        rst = 1'b0;
    endtask

    task automatic t_activate_read();
        issue(C_ACT, 1, 1'b0);
        expect_ok("R3 act", C_ACT);
        check("R3 bank1 opening", st(1), 1);
        check("R2 bank0 untouched", st(0), 0);
        nops(1);
        check("R3 still opening", st(1), 1);
        issue(C_RD, 1, 1'b0);
        expect_err("R3 read before TRCD", 4);
        check("R3 open at TRCD edge", st(1), 2);
        issue(C_RD, 1, 1'b0);
        expect_ok("R3 read at TRCD", C_RD);
        check("R9 read state", st(1), 3);
        nops(2);
        check("R9 still reading", st(1), 3);
        nops(1);
        check("R9 back to open", st(1), 2);
        issue(C_PRE, 1, 1'b0);
        check("R5 closing", st(1), 8);
        nops(2);
        check("R5 idle after TRP", st(1), 0);
    endtask

    task automatic t_idle_access();
        issue(C_RD, 2, 1'b0);
        expect_err("R4 read idle", 1);
        issue(C_WR, 2, 1'b0);
        expect_err("R4 write idle", 1);
        check("R11 idle stays idle", st(2), 0);
        issue(C_ACT, 2, 1'b0);
        nops(2);
        check("R4 bank2 open", st(2), 2);
        issue(C_ACT, 2, 1'b0);
        expect_err("R4 act open row", 2);
        check("R11 open unchanged", st(2), 2);
        close_all();
    endtask

    task automatic t_tras();
        issue(C_ACT, 0, 1'b0);
        nops(3);
        issue(C_PRE, 0, 1'b0);
        expect_err("R6 early precharge", 5);
        check("R6 stays open", st(0), 2);
        issue(C_PRE, 0, 1'b0);
        expect_ok("R6 precharge at TRAS", C_PRE);
        check("R6 closing", st(0), 8);
        nops(2);
        check("R6 idle", st(0), 0);
    endtask

    task automatic t_rrd();
        issue(C_ACT, 0, 1'b0);
        issue(C_ACT, 1, 1'b0);
        expect_err("R7 act too soon", 6);
        check("R7 bank1 idle", st(1), 0);
        issue(C_ACT, 1, 1'b0);
        expect_ok("R7 act at TRRD", C_ACT);
        issue(C_ACT, 2, 1'b0);
        expect_err("R7 third act too soon", 6);
        issue(C_RD, 3, 1'b0);
        expect_err("R11 other bank own state", 1);
        nops(5);
        issue(C_PRE, 2, 1'b1);
        check("R5 all close bank0", st(0), 8);
        check("R5 all close bank1", st(1), 8);
        check("R5 idle bank stays idle", st(2), 0);
        nops(2);
        check("R5 bank0 idle", st(0), 0);
    endtask

    task automatic t_pre_single();
        issue(C_ACT, 0, 1'b0);
        nops(1);
        issue(C_ACT, 3, 1'b0);
        nops(5);
        issue(C_PRE, 3, 1'b0);
        check("R5 single closes bank3", st(3), 8);
        check("R5 single leaves bank0", st(0), 2);
        nops(2);
        check("R5 bank3 idle", st(3), 0);
        check("R5 bank0 still open", st(0), 2);
        issue(C_PRE, 0, 1'b1);
        check("R5 all closes bank0", st(0), 8);
        nops(2);
    endtask

    task automatic t_priority();
        issue(C_ACT, 1, 1'b0);
        nops(1);
        issue(C_ACT, 3, 1'b0);
        issue(C_PRE, 0, 1'b1);
        expect_err("R11 lowest bank code", 5);
        check("R11 bank1 unchanged", st(1), 2);
        check("R11 bank3 unchanged", st(3), 1);
        close_all();
    endtask

    task automatic t_mode_refresh();
        issue(C_ACT, 2, 1'b0);
        issue(C_MRS, 0, 1'b0);
        expect_err("R8 mode set not idle", 3);
        check("R8 bank2 opening", st(2), 1);
        close_all();
        issue(C_MRS, 0, 1'b0);
        expect_ok("R8 mode set", C_MRS);
        check("R8 bank0 mode busy", st(0), 10);
        check("R8 bank3 mode busy", st(3), 10);
        issue(C_ACT, 0, 1'b0);
        expect_err("R8 act during mode busy", 4);
        check("R8 idle after TMRD", st(0), 0);
        issue(C_REF, 0, 1'b0);
        expect_ok("R8 refresh", C_REF);
        check("R8 refreshing", st(1), 9);
        nops(6);
        check("R8 still refreshing", st(1), 9);
        nops(1);
        check("R8 idle after TRFC", st(1), 0);
    endtask

    task automatic t_autoclose();
        issue(C_ACT, 1, 1'b0);
        nops(2);
        issue(C_RD, 1, 1'b1);
        check("R9 read auto-close", st(1), 5);
        issue(C_RD, 1, 1'b0);
        expect_err("R9 access during auto-close", 4);
        nops(1);
        check("R9 still reading", st(1), 5);
        nops(1);
        check("R9 closing", st(1), 8);
        nops(2);
        check("R9 idle", st(1), 0);
        issue(C_ACT, 1, 1'b0);
        nops(2);
        issue(C_WR, 1, 1'b1);
        check("R9 write auto-close", st(1), 6);
        nops(4);
        check("R9 write closing", st(1), 8);
        nops(2);
        check("R9 write idle", st(1), 0);
    endtask

    task automatic t_write();
        issue(C_ACT, 2, 1'b0);
        nops(2);
        issue(C_WR, 2, 1'b0);
        expect_ok("R10 write", C_WR);
        check("R10 writing", st(2), 4);
        nops(2);
        check("R10 still writing", st(2), 4);
        nops(1);
        check("R10 recovery", st(2), 7);
        nops(1);
        check("R10 open after recovery", st(2), 2);
        issue(C_WR, 2, 1'b0);
        issue(C_BST, 0, 1'b0);
        expect_ok("R10 burst stop", C_BST);
        check("R10 stop write", st(2), 2);
        issue(C_RD, 2, 1'b0);
        issue(C_BST, 0, 1'b0);
        check("R10 stop read", st(2), 2);
        issue(C_PRE, 2, 1'b0);
        nops(2);
    endtask

    task automatic t_cke_desel();
        issue_ck(C_RD, 0, 1'b0, 1'b0);
        check("R1 cke low cmd", int'(cmd_o), C_NOP);
        check("R1 cke low ignored", int'(err_o), 0);
        check("R1 cke low no state", st(0), 0);
        issue(C_DESEL, 0, 1'b0);
        expect_ok("R1 deselect", C_DESEL);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    initial begin
        t_reset();
        nops(2);
        t_activate_read();
        t_idle_access();
        t_tras();
        nops(3);
        t_rrd();
        nops(3);
        t_pre_single();
        nops(3);
        t_priority();
        t_mode_refresh();
        nops(3);
        t_autoclose();
        nops(3);
        t_write();
        t_cke_desel();
        nops(2);
        finish_run();
    end
endmodule